// File: doc/BRIEF.md
# Page-buffered write controller

This block is the write front end of a byte-wide non-volatile memory organised in 128-byte pages. A host writes bytes with active-low chip-enable, write-enable and output-enable strobes. All three are sampled on the system clock. Each accepted byte goes into a page buffer, and a valid flag is set for its position. The first accepted byte opens a load window. Every further byte on the same page keeps the window open. When no byte has arrived for a set number of cycles, the window closes and the page goes to a programming stage. After a fixed program time, that stage copies only the flagged bytes into the array model.

Writes are blocked in four cases:
- during a power-on lockout after the power-valid input rises;
- for strobe pulses too short to pass the filter;
- while the output enable is low;
- while the protect logic holds the write-accept input low.

Writes are also refused while programming runs. A read port returns array contents so that programmed data can be observed. All timing values are parameters in clock cycles. With the default page-select width the address is 10 bits, which gives 8 pages.

Top module: `pgwr_ctrl`

## Requirements
- R1: A page holds 128 bytes. addr[6:0] selects the byte within the page, and the bits above bit 6 select the page.
- R2: The load window closes TBLC_CYC cycles after the clock edge that accepted the last byte, and `busy` rises at that point. `busy` stays high for exactly PROG_CYC cycles. The array is updated in the cycle `busy` falls.
- R3: All bytes of one load must carry the page bits of the first byte. A byte for another page is dropped, the load goes on, and its timeout is not restarted.
- R4: Bytes may arrive in any order. A position written twice in one load is programmed with its latest value.
- R5: Only flagged positions of the page change in the array; all other array bytes keep their value. Every array byte reads FFh after reset.
- R6: The address is taken in the cycle in which the later of CE/WE is first seen low. The data is the value present in the last cycle in which both were seen low.
- R7: A write needs `oe_n` high throughout. A strobe pulse during which `oe_n` is low, or that ends with `oe_n` low, writes nothing.
- R8: A pulse in which CE and WE are both low for fewer than FILT_CYC clock samples is ignored. A pulse of FILT_CYC samples or more is accepted.
- R9: No write is accepted until `pwr_ok` has been high for POR_CYC cycles. `pwr_ok` low restarts this delay.
- R10: Writes are refused while `busy` is high. The valid flags are cleared when programming ends, so the next load programs only its own bytes.
- R11: A write made while `wr_accept` is low is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply valid indication |
| wr_accept | input | 1 | Write permission from the protect logic |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | PAGE_W+7 | Write address |
| din | input | 8 | Write data |
| rd_addr | input | PAGE_W+7 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | High while the page is being programmed |

## Verification
The main table loads one page in the following ways:
- positions out of order, to show that the offset bits place each byte;
- one position written twice, to show that the latest value wins;
- a byte for a foreign page in the middle of the load, to show that a mismatch is dropped rather than ending or corrupting the load.

After this load, a byte on the same page that was never written must still read FFh, which separates flagged programming from a copy of the whole page. The exact cycles at which `busy` rises and falls pin down the window and the program time.

A second load on a different page has two purposes:
- it shows that the valid flags from the first load do not carry over;
- it shows that a write issued during programming is lost.

Directed pulses probe the other blocking and capture rules:
- 1-sample and 2-sample strobes test the filter threshold;
- writes with `oe_n` low, with `wr_accept` low and during the power-on delay must all be blocked;
- a write whose address and data both change while the strobes are still partly asserted shows when the address and the data are captured.

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
  parameter int PAGE_W   = 3,
  parameter int FILT_CYC = 2,
  parameter int TBLC_CYC = 15000,
  parameter int PROG_CYC = 500000,
  parameter int POR_CYC  = 500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_ok,
  input  logic                    wr_accept,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    oe_n,
  input  logic [PAGE_W+6:0]       addr,
  input  logic [7:0]              din,
  input  logic [PAGE_W+6:0]       rd_addr,
  output logic [7:0]              rd_data,
  output logic                    busy
);
  localparam int OFS_W  = 7;
  localparam int NBYTE  = 1 << OFS_W;
  localparam int ADDR_W = PAGE_W + OFS_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PW = $clog2(POR_CYC + 1);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int TW = $clog2(TBLC_CYC + 1);
  localparam int GW = $clog2(PROG_CYC + 1);
  localparam logic [PW-1:0] POR_MAX  = PW'(POR_CYC);
  localparam logic [FW-1:0] FLT_MAX  = FW'(FILT_CYC);
  localparam logic [TW-1:0] TMR_LAST = TW'(TBLC_CYC - 1);
  localparam logic [GW-1:0] PGM_LAST = GW'(PROG_CYC - 1);

  typedef enum logic [1:0] {IDLE, LOAD, PROG} st_t;

  st_t               st;
  logic [PW-1:0]     por_cnt;
  logic [FW-1:0]     flt;
  logic [TW-1:0]     tmr;
  logic [GW-1:0]     pcnt;
  logic              act_q;
  logic [ADDR_W-1:0] alat;
  logic [7:0]        dlat;
  logic [PAGE_W-1:0] pg;
  logic [NBYTE-1:0]  vld;
  logic [7:0]        pbuf [NBYTE];
  logic [7:0]        mem  [DEPTH];

  wire por_done  = (por_cnt == POR_MAX);
  wire act       = !ce_n && !we_n && oe_n;
  wire rel       = act_q && !act && oe_n;
  wire try_wr    = rel && (flt == FLT_MAX) && por_done && wr_accept && (st != PROG);
  wire same_pg   = (alat[ADDR_W-1:OFS_W] == pg);
  wire take      = try_wr && ((st == IDLE) || same_pg);
  wire prog_done = (st == PROG) && (pcnt == PGM_LAST);

  assign busy    = (st == PROG);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               por_cnt <= '0;
    else if (!pwr_ok)         por_cnt <= '0;
    else if (!por_done)       por_cnt <= por_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      flt   <= '0;
      alat  <= '0;
      dlat  <= '0;
    end else begin
      act_q <= act;
      if (act) dlat <= din;
      if (act && !act_q) begin
        alat <= addr;
        flt  <= FW'(1);
      end else if (act && flt != FLT_MAX) begin
        flt <= flt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= IDLE;
      tmr  <= '0;
      pcnt <= '0;
      pg   <= '0;
      vld  <= '0;
    end else begin
      if (take) vld[alat[OFS_W-1:0]] <= 1'b1;
      case (st)
        IDLE: if (take) begin
          st  <= LOAD;
          pg  <= alat[ADDR_W-1:OFS_W];
          tmr <= '0;
        end
        LOAD: begin
          if (take) tmr <= '0;
          else if (tmr == TMR_LAST) begin
            st   <= PROG;
            pcnt <= '0;
          end else tmr <= tmr + 1'b1;
        end
        PROG: begin
          if (prog_done) begin
            st  <= IDLE;
            vld <= '0;
          end else pcnt <= pcnt + 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) pbuf[alat[OFS_W-1:0]] <= dlat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_done) begin
      for (int j = 0; j < NBYTE; j++)
        if (vld[j]) mem[{pg, OFS_W'(j)}] <= pbuf[j];
    end
  end
endmodule

// File: rtl/pgwr_ctrl_chk.sv
module pgwr_ctrl_chk #(
  parameter int FILT_CYC = 2,
  parameter int TBLC_CYC = 15000,
  parameter int POR_CYC  = 500000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pwr_ok,
  input logic         ce_n,
  input logic         we_n,
  input logic         oe_n,
  input logic         busy,
  input logic         take,
  input logic [127:0] vld
);
  localparam int PW = $clog2(POR_CYC + 2);
  localparam int RW = $clog2(FILT_CYC + 2);
  localparam int GW = $clog2(TBLC_CYC + 2);

  logic [PW-1:0] pc;
  logic [RW-1:0] rc;
  logic [GW-1:0] gap;
  logic          low_q;
  wire low = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; rc <= '0; gap <= '0; low_q <= 1'b0;
    end else begin
      low_q <= low;
      if (!pwr_ok) pc <= '0;
      else if (pc != PW'(POR_CYC)) pc <= pc + 1'b1;
      if (low && !low_q) rc <= RW'(1);
      else if (low && rc != RW'(FILT_CYC)) rc <= rc + 1'b1;
      if (take) gap <= '0;
      else if (gap != GW'(TBLC_CYC + 1)) gap <= gap + 1'b1;
    end
  end

  assert_por_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pc == PW'(POR_CYC)));
  assert_short_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (rc >= RW'(FILT_CYC)));
  assert_window_timeout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (gap >= GW'(TBLC_CYC - 1)));
  assert_flags_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (vld == '0));
endmodule

bind pgwr_ctrl pgwr_ctrl_chk #(.FILT_CYC(FILT_CYC), .TBLC_CYC(TBLC_CYC), .POR_CYC(POR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
  .busy(busy), .take(take), .vld(vld)
);

// File: tb/test_pgwr_ctrl.sv
module test_pgwr_ctrl;
  localparam int PAGE_W = 3, FILT = 2, TBLC = 30, PROG = 10, POR = 20;
  localparam int AW = PAGE_W + 7;
  localparam int NV = 6;
  // {addr[9:0], data[7:0], lands}
  localparam logic [18:0] VEC [NV] = '{
    {10'h105, 8'hA1, 1'b1}, {10'h17F, 8'hB2, 1'b1}, {10'h100, 8'hC3, 1'b1},
    {10'h305, 8'hEE, 1'b0}, {10'h105, 8'hD4, 1'b1}, {10'h140, 8'h5A, 1'b1}};

  logic clk = 0, rst_n = 0, pwr_ok = 0, wr_accept = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1, busy;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0] din = '0, rd_data;
  int total = 0, bad = 0;
  logic [7:0] expm [1 << AW];

  always #5 clk = ~clk;

  pgwr_ctrl #(.PAGE_W(PAGE_W), .FILT_CYC(FILT), .TBLC_CYC(TBLC), .PROG_CYC(PROG), .POR_CYC(POR)) i_pgwr_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .wr_accept(wr_accept), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input int len);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    repeat (len - 1) @(negedge clk);
    @(negedge clk); ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); rd_addr = a; #1 v = rd_data;
  endtask

  task automatic settle();
    repeat (TBLC + PROG + 10) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < (1 << AW); i++) expm[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset busy", {7'd0, busy}, 8'h00);
    rd(10'h000, v); chk("R5 reset array", v, 8'hFF);

    pwr_ok = 1;
    wr(10'h005, 8'h11, 2);
    settle();
    rd(10'h005, v); chk("R9 lockout", v, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:9], VEC[i][8:1], 2);
      if (VEC[i][0]) expm[VEC[i][18:9]] = VEC[i][8:1];
    end
    repeat (TBLC - 1) @(negedge clk);
    chk("R2 window open", {7'd0, busy}, 8'h00);
    @(negedge clk);
    chk("R2 busy rises", {7'd0, busy}, 8'h01);
    repeat (PROG - 1) @(negedge clk);
    chk("R2 busy holds", {7'd0, busy}, 8'h01);
    @(negedge clk);
    chk("R2 busy falls", {7'd0, busy}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      rd(VEC[i][18:9], v);
      chk("R1 R3 R4 table", v, expm[VEC[i][18:9]]);
    end
    rd(10'h101, v); chk("R5 untouched byte", v, 8'hFF);

    wr(10'h080, 8'h77, 2);
    repeat (TBLC + 1) @(negedge clk);
    wr(10'h081, 8'h66, 2);
    settle();
    rd(10'h080, v); chk("R10 second load", v, 8'h77);
    rd(10'h081, v); chk("R10 write while busy", v, 8'hFF);
    rd(10'h085, v); chk("R10 flags cleared", v, 8'hFF);

    wr(10'h000, 8'h12, 1);
    settle();
    rd(10'h000, v); chk("R8 short pulse", v, 8'hFF);
    wr(10'h000, 8'h34, 2);
    settle();
    rd(10'h000, v); chk("R8 long pulse", v, 8'h34);

    oe_n = 0; wr(10'h001, 8'h44, 3); oe_n = 1;
    settle();
    rd(10'h001, v); chk("R7 oe low", v, 8'hFF);

    wr_accept = 0; wr(10'h002, 8'h56, 2); wr_accept = 1;
    settle();
    rd(10'h002, v); chk("R11 refused", v, 8'hFF);

    @(negedge clk); addr = 10'h010; din = 8'hAA; ce_n = 0;
    @(negedge clk); addr = 10'h011; we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1; din = 8'hBB; addr = 10'h012;
    @(negedge clk); ce_n = 1;
    settle();
    rd(10'h011, v); chk("R6 later fall addr", v, 8'hAA);
    rd(10'h010, v); chk("R6 early addr", v, 8'hFF);
    rd(10'h012, v); chk("R6 late addr", v, 8'hFF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule